// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for every received frame, whether the frame is kept or dropped. It looks only at the 48-bit destination address, which arrives one byte per accepted cycle as the header streams in. Three tests are applied to that address. The first compares it against a programmed station address. The second runs a CRC-32 over the six address bytes and uses the top bits of the result to pick one bit of a 512-bucket hash table. The hash table has an individual half and a group half. The third applies the promiscuous and broadcast-reject controls.

Software sets up the station address, the sixteen hash words and the control flags through a write-only register port. There is one address per 32-bit word. After the sixth address byte of a frame, the block raises a one-cycle decision strobe that carries the accept/reject result. The receive data path, FCS checking and frame storage are outside this block.

Top module: `rx_addr_filter`

## Requirements
- R1: The programmed station address is held in two registers. Register 16 holds address bytes 5, 4, 3 and 2 in bits 31:24, 23:16, 15:8 and 7:0. Register 17 holds byte 1 in bits 31:24 and byte 0 in bits 23:16. Byte 0 is the first byte to arrive. A destination equal to this address is accepted.
- R2: The CRC is the reflected Ethernet CRC-32 (polynomial 0xEDB88320) taken over the six bytes in arrival order, least significant bit first. Its initial value is all ones and the result is complemented at the end. In normal mode a unicast destination uses CRC bits 31:24 as its bucket index, which always falls in the individual half (buckets 0 to 255).
- R3: In normal mode a multicast destination (bit 0 of byte 0 set) adds 256 to its 8-bit index, so it only hits the group half (buckets 256 to 511).
- R4: In extended mode (control bit 4 set) every destination uses CRC bits 31:23 as a 9-bit bucket index, whether it is unicast or multicast.
- R5: Bucket b lives in hash register b[8:5] (registers 0 to 15). Inside that register it is bit 31 - b[4:0]. A destination whose bucket bit is set is accepted.
- R6: An all-ones destination is treated as broadcast before any other test. It is accepted only when broadcast reject (control bit 3) is clear or full promiscuous mode is set. Its hash bucket and the multicast-promiscuous flag play no part.
- R7: With full promiscuous mode set (control bit 0), every frame is accepted.
- R8: Unicast-promiscuous mode (control bit 1) accepts every non-multicast destination. Multicast-promiscuous mode (control bit 2) accepts every non-broadcast multicast destination. Neither flag affects the other class.
- R9: The decision strobe is high for exactly one cycle, the cycle after the sixth address byte is taken. A byte flagged as first always restarts the address. Unflagged bytes after the sixth, and idle cycles between bytes, have no effect.
- R10: Reset clears all hash words, the station address and the control flags, and holds the decision strobe low.
- R11: A write to register 18 sets the control flags from data bits 4:0. A write to register 0 to 15 replaces that hash word whole. Both take effect for the following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register number |
| cfg_wdata | input | 32 | Register write data |
| hdr_valid | input | 1 | Address byte present this cycle |
| hdr_first | input | 1 | Byte is byte 0 of a new destination |
| hdr_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted when dec_valid is high |

## Verification
The bench builds the block with its default sizes: sixteen 32-bit hash words, which together make exactly the 512 buckets that a 9-bit index addresses. With that size every bucket position is reachable, and the bench can hit both table halves on purpose. It can also set the deliberately wrong half for a bucket, in both normal and extended mode, and it derives the buckets from its own CRC. Directed sequences then cover reset clearing, the strobe timing with idle gaps, stray bytes after the sixth, and a restart in the middle of an address.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int CRC_W      = 32;
    localparam int IDX_W      = 9;

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_SEED      = '1;

    // register numbers on the write port
    localparam int REG_STA_LO = 16;
    localparam int REG_STA_HI = 17;
    localparam int REG_CTRL   = 18;

    // control word, bit 0 is all_prom
    typedef struct packed {
        logic ext_hash;
        logic bc_reject;
        logic mc_prom;
        logic uc_prom;
        logic all_prom;
    } filt_ctrl_t;

    typedef struct packed {
        logic bcast;
        logic mcast;
        logic station;
    } addr_class_t;

    // one reflected CRC step over a byte, LSB first
    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] cur,
                                                       input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] c;
        c = cur ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int k = 0; k < BYTE_W; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/af_cfg_regs.sv
module af_cfg_regs
    import addr_filt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CFG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [ADDR_BYTES*BYTE_W-1:0] station,
    output filt_ctrl_t        ctrl
);
    localparam int CTRL_W = $bits(filt_ctrl_t);

    logic [WORD_W-1:0] sta_lo_q;
    logic [15:0]       sta_hi_q;
    filt_ctrl_t        ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sta_lo_q <= '0;
            sta_hi_q <= '0;
            ctrl_q   <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(REG_STA_LO)) sta_lo_q <= cfg_wdata;
            if (cfg_addr == CFG_AW'(REG_STA_HI)) sta_hi_q <= cfg_wdata[31:16];
            if (cfg_addr == CFG_AW'(REG_CTRL))   ctrl_q   <= filt_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        end
    end

    // arrival order: byte 0 sits in the top byte of station
    assign station = {sta_hi_q[7:0], sta_hi_q[15:8],
                      sta_lo_q[7:0], sta_lo_q[15:8], sta_lo_q[23:16], sta_lo_q[31:24]};
    assign ctrl = ctrl_q;

    assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_AW'(REG_CTRL)) |=> (ctrl_q == filt_ctrl_t'($past(cfg_wdata[CTRL_W-1:0]))));

    assert_ctrl_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_q == '0));

endmodule

// File: rtl/af_hash_table.sv
module af_hash_table
    import addr_filt_pkg::*;
#(
    parameter int HASH_WORDS = 16,
    parameter int WORD_W     = 32,
    parameter int CFG_AW     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [IDX_W-1:0]  bucket,
    output logic              hit
);
    localparam int BIT_SEL_W  = $clog2(WORD_W);
    localparam int WORD_SEL_W = $clog2(HASH_WORDS);

    logic [WORD_W-1:0] word_q [HASH_WORDS];

    for (genvar w = 0; w < HASH_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[w] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(w)) begin
                word_q[w] <= cfg_wdata;
            end
        end

        assert_word_clear_R10: assert property (@(posedge clk)
            $past(rst) |-> (word_q[w] == '0));

        assert_word_write_R11: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_addr == CFG_AW'(w)) |=> (word_q[w] == $past(cfg_wdata)));
    end

    logic [WORD_SEL_W-1:0] word_sel;
    logic [BIT_SEL_W-1:0]  bit_sel;

    always_comb begin
        word_sel = bucket[IDX_W-1 -: WORD_SEL_W];
        // bucket bit 0 of a word is its most significant bit
        bit_sel  = BIT_SEL_W'(WORD_W - 1) - bucket[BIT_SEL_W-1:0];
        hit      = word_q[word_sel][bit_sel];
    end

endmodule

// File: rtl/af_crc_unit.sv
module af_crc_unit
    import addr_filt_pkg::*;
#(
    parameter int OUT_W = IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              restart,
    input  logic [BYTE_W-1:0] data,
    output logic [OUT_W-1:0]  crc_top
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;
    logic [CRC_W-1:0] crc_upd;

    always_comb begin
        crc_base = restart ? CRC_SEED : crc_q;
        crc_upd  = crc_step_byte(crc_base, data);
        crc_top  = ~crc_upd[CRC_W-1 -: OUT_W];
    end

    always_ff @(posedge clk) begin
        if (rst)       crc_q <= CRC_SEED;
        else if (step) crc_q <= crc_upd;
    end

    assert_crc_seed_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(step)) |-> $stable(crc_q));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import addr_filt_pkg::*;
#(
    parameter int HASH_WORDS = 16,
    parameter int WORD_W     = 32,
    parameter int CFG_AW     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              hdr_valid,
    input  logic              hdr_first,
    input  logic [7:0]        hdr_byte,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int CNT_W   = $clog2(ADDR_BYTES + 1);
    localparam int HOLD_N  = ADDR_BYTES - 1;
    localparam int DEST_W  = ADDR_BYTES * BYTE_W;

    logic [DEST_W-1:0] station;
    filt_ctrl_t        ctrl;

    af_cfg_regs #(.WORD_W(WORD_W), .CFG_AW(CFG_AW)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .station(station), .ctrl(ctrl)
    );

    // byte capture
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  pos;
    logic              take_first, take_more, take, last_byte;
    logic [BYTE_W-1:0] held_q [HOLD_N];

    always_comb begin
        take_first = hdr_valid && hdr_first;
        take_more  = hdr_valid && !hdr_first && (cnt_q != '0);
        take       = take_first || take_more;
        pos        = take_first ? '0 : cnt_q;
        last_byte  = take && (pos == CNT_W'(ADDR_BYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= last_byte ? '0 : pos + 1'b1;
        end
    end

    for (genvar i = 0; i < HOLD_N; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)                              held_q[i] <= '0;
            else if (take && pos == CNT_W'(i))    held_q[i] <= hdr_byte;
        end
    end

    // CRC over the address
    logic [IDX_W-1:0] crc_top;

    af_crc_unit #(.OUT_W(IDX_W)) u_crc (
        .clk(clk), .rst(rst), .step(take), .restart(take_first),
        .data(hdr_byte), .crc_top(crc_top)
    );

    // classification of the complete address
    logic [DEST_W-1:0] dest;
    addr_class_t       cls;
    logic [IDX_W-1:0]  bucket;
    logic              hash_hit;

    always_comb begin
        for (int i = 0; i < HOLD_N; i++) begin
            dest[DEST_W-1-i*BYTE_W -: BYTE_W] = held_q[i];
        end
        dest[BYTE_W-1:0] = hdr_byte;
        cls.bcast   = &dest;
        cls.mcast   = dest[DEST_W-BYTE_W];
        cls.station = (dest == station);
        bucket = ctrl.ext_hash ? crc_top : {cls.mcast, crc_top[IDX_W-1:1]};
    end

    af_hash_table #(.HASH_WORDS(HASH_WORDS), .WORD_W(WORD_W), .CFG_AW(CFG_AW)) u_hash (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bucket(bucket), .hit(hash_hit)
    );

    logic accept_c;

    always_comb begin
        if (cls.bcast) begin
            accept_c = ctrl.all_prom || !ctrl.bc_reject;
        end else begin
            accept_c = cls.station || hash_hit || ctrl.all_prom ||
                       (cls.mcast ? ctrl.mc_prom : ctrl.uc_prom);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= last_byte;
            dec_accept <= last_byte && accept_c;
        end
    end

    always_comb begin
        assert_cnt_range_R9: assert (rst || cnt_q < CNT_W'(ADDR_BYTES));
    end

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    assert_needs_byte_R9: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(hdr_valid));

    assert_bcast_block_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(last_byte && cls.bcast && ctrl.bc_reject && !ctrl.all_prom))
        |-> (dec_valid && !dec_accept));

    assert_prom_all_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(last_byte && ctrl.all_prom)) |-> (dec_valid && dec_accept));

    assert_station_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(last_byte && cls.station && !cls.bcast)) |-> dec_accept);

endmodule

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        hdr_valid;
    logic        hdr_first;
    logic [7:0]  hdr_byte;
    logic        dec_valid;
    logic        dec_accept;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rx_addr_filter uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid), .hdr_first(hdr_first),
        .hdr_byte(hdr_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    localparam logic [47:0] ST = 48'h02_11_22_33_44_55;
    localparam logic [47:0] UO = 48'h02_11_22_33_44_56;
    localparam logic [47:0] MC = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;

    // hs: 0 no bucket set, 1 own bucket set, 2 bucket with bit 8 flipped set
    typedef struct packed {
        logic [47:0] dest;
        logic [4:0]  ctrl;
        logic [1:0]  hs;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{ST, 5'd0,  2'd0, 1'b1, 4'd1},  // R1 station hit
        '{UO, 5'd0,  2'd0, 1'b0, 4'd1},  // R1 near miss
        '{UO, 5'd0,  2'd1, 1'b1, 4'd2},  // R2 unicast individual bucket
        '{UO, 5'd0,  2'd2, 1'b0, 4'd2},  // R2 group half does not serve unicast
        '{MC, 5'd0,  2'd0, 1'b0, 4'd3},  // R3 empty table
        '{MC, 5'd0,  2'd1, 1'b1, 4'd3},  // R3 group bucket
        '{MC, 5'd0,  2'd2, 1'b0, 4'd3},  // R3 individual half ignored
        '{MC, 5'd16, 2'd1, 1'b1, 4'd4},  // R4 extended multicast
        '{UO, 5'd16, 2'd1, 1'b1, 4'd4},  // R4 extended unicast
        '{MC, 5'd16, 2'd2, 1'b0, 4'd4},  // R4 wrong 9-bit bucket
        '{BC, 5'd0,  2'd0, 1'b1, 4'd6},  // R6 broadcast passes
        '{BC, 5'd8,  2'd0, 1'b0, 4'd6},  // R6 broadcast rejected
        '{BC, 5'd8,  2'd1, 1'b0, 4'd6},  // R6 hash ignored for broadcast
        '{BC, 5'd12, 2'd0, 1'b0, 4'd6},  // R6 mc promisc ignored for broadcast
        '{BC, 5'd9,  2'd0, 1'b1, 4'd7},  // R7 full promisc beats reject
        '{UO, 5'd1,  2'd0, 1'b1, 4'd7},  // R7
        '{MC, 5'd1,  2'd0, 1'b1, 4'd7},  // R7
        '{UO, 5'd2,  2'd0, 1'b1, 4'd8},  // R8 uc promisc
        '{MC, 5'd2,  2'd0, 1'b0, 4'd8},  // R8 uc promisc not for multicast
        '{MC, 5'd4,  2'd0, 1'b1, 4'd8},  // R8 mc promisc
        '{UO, 5'd4,  2'd0, 1'b0, 4'd8},  // R8 mc promisc not for unicast
        '{ST, 5'd8,  2'd0, 1'b1, 4'd1}   // R1 station with broadcast reject on
    };

    function automatic logic [31:0] ref_crc(input logic [47:0] d);
        logic [31:0] c;
        logic [7:0]  b;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            b = d[47-8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB8_8320;
                else             c = c >> 1;
            end
        end
        return ~c;
    endfunction

    function automatic logic [8:0] ref_bucket(input logic [47:0] d, input logic ext);
        logic [31:0] c;
        c = ref_crc(d);
        if (ext) return c[31:23];
        return {d[40], c[31:24]};
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_bucket(input logic [8:0] b, input logic on);
        wr(int'(b[8:5]), on ? (32'h8000_0000 >> b[4:0]) : 32'h0);
    endtask

    // sends n bytes of d starting at byte 0, gap idle cycles between bytes;
    // returns at the negedge right after the last byte's edge
    task automatic send(input logic [47:0] d, input int n, input int gap, input logic first);
        for (int i = 0; i < n; i++) begin
            hdr_valid = 1'b1;
            hdr_first = first && (i == 0);
            hdr_byte  = d[47-8*i -: 8];
            @(negedge clk);
            hdr_valid = 1'b0;
            hdr_first = 1'b0;
            if (i < n - 1) begin
                repeat (gap) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic [8:0] bk;

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        hdr_valid = 1'b0; hdr_first = 1'b0; hdr_byte = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 strobe low after reset", dec_valid, 1'b0);

        // R10: state written before a reset is gone afterwards
        wr(18, 32'h1);
        bk = ref_bucket(UO, 1'b0);
        set_bucket(bk, 1'b1);
        wr(16, 32'h5544_3322);
        wr(17, 32'h1102_0000);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        send(UO, 6, 0, 1'b1);
        chk("R10 valid after reset", dec_valid, 1'b1);
        chk("R10 hash/ctrl cleared", dec_accept, 1'b0);
        send(ST, 6, 0, 1'b1);
        chk("R10 station cleared", dec_accept, 1'b0);

        // program the station address
        wr(16, 32'h5544_3322);
        wr(17, 32'h1102_0000);

        for (int v = 0; v < NV; v++) begin
            wr(18, {27'd0, VECS[v].ctrl});
            bk = ref_bucket(VECS[v].dest, VECS[v].ctrl[4]);
            if (VECS[v].hs == 2'd2) bk[8] = ~bk[8];
            if (VECS[v].hs != 2'd0) set_bucket(bk, 1'b1);
            send(VECS[v].dest, 6, 0, 1'b1);
            checks++;
            if (dec_valid !== 1'b1 || dec_accept !== VECS[v].exp) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual=%0b/%0b expected=1/%0b",
                         VECS[v].req, v, dec_valid, dec_accept, VECS[v].exp);
            end
            if (VECS[v].hs != 2'd0) set_bucket(bk, 1'b0);
        end
        wr(18, 32'h0);

        // R5: explicit word/bit placement, bucket 0x1A3 -> word 13, bit 28
        begin
            logic [47:0] d;
            bit found;
            found = 0;
            d = 48'h02_00_00_00_00_00;
            for (int t = 0; t < 4096 && !found; t++) begin
                d[15:0] = 16'(t);
                if (ref_bucket(d, 1'b1) == 9'h1A3) found = 1;
            end
            wr(18, 32'h10);
            wr(13, 32'h1000_0000);
            send(d, 6, 0, 1'b1);
            chk("R5 word 13 bit 28 hit", dec_accept, found);
            wr(13, 32'h0800_0000);
            send(d, 6, 0, 1'b1);
            chk("R5 neighbour bit misses", dec_accept, 1'b0);
            wr(13, 32'h0);
            wr(18, 32'h0);
        end

        // R9: timing with gaps, strobe only after sixth byte, one cycle wide
        send(ST, 5, 2, 1'b1);
        chk("R9 no strobe before sixth byte", dec_valid, 1'b0);
        repeat (2) @(negedge clk);
        send(ST << 40, 1, 0, 1'b0);
        chk("R9 strobe after sixth byte", dec_valid, 1'b1);
        chk("R9 accept with gaps", dec_accept, 1'b1);
        @(negedge clk);
        chk("R9 strobe one cycle", dec_valid, 1'b0);

        // R9: stray bytes after the sixth do nothing
        send(ST, 4, 0, 1'b0);
        chk("R9 stray bytes ignored", dec_valid, 1'b0);

        // R9: restart in the middle of an address
        send(UO, 3, 0, 1'b1);
        send(ST, 6, 0, 1'b1);
        chk("R9 restart strobe", dec_valid, 1'b1);
        chk("R9 restart uses new address", dec_accept, 1'b1);

        // R11: control write takes effect for the next frame
        wr(18, 32'h2);
        send(UO, 6, 0, 1'b1);
        chk("R11 control write applied", dec_accept, 1'b1);
        wr(18, 32'h0);
        send(UO, 6, 0, 1'b1);
        chk("R11 control cleared by write", dec_accept, 1'b0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule